// File: doc/BRIEF.md
# Per-Link Transmit Signaling Processor

This block produces the transmit-side signaling and alarm bits for one DS1 or E1 link. It holds one signaling code per channel. The codes come either from host writes or from signaling extracted on the receive line. For extracted codes, an optional debounce accepts a code only after it has been seen twice in a row on the same channel. Per-link control bits and receive alignment flags are captured once per multiframe. The derived outputs therefore change only at multiframe starts.

The derived outputs are:
- the timeslot-16 remote multiframe alarm bit;
- four handling-group spare bits;
- the effective signaling format;
- a per-bit payload mask, which clears the robbed-bit position of DS1 voice timeslots when stomping is enabled.

The spare bits come from a small state machine with three states: SP_DEFAULT, SP_FORCED and SP_AUTO. The next state is chosen on every multiframe start. A force-to-zero request selects SP_FORCED. Otherwise, automatic maintenance selects SP_AUTO. With neither request, the machine goes to SP_DEFAULT.

Each channel also has a debounce machine with two states. In DB_IDLE, an extracted code arms a candidate and moves to DB_ARMED. In DB_ARMED, the next extracted code for the channel commits if it matches the candidate. The machine returns to DB_IDLE either way, so a differing code discards the candidate. A host write forces DB_IDLE.

Top module: `tx_sig_proc`

## Requirements
- R1: After reset, tx_y is 0, tx_sp is 4'b1111, eff_fmt is 0, pay_mask is 8'hFF and every stored code reads 0.
- R2: When the sampled controls have cfg_e1=1 and cfg_auto_y=1, tx_y is the inverse of the sampled rx_ts16_aligned, whatever host_y is.
- R3: Otherwise, tx_y equals the host_y value that was sampled.
- R4: Controls and receive status are sampled only on a clock edge with mf_start=1. On any other edge, tx_y, tx_sp and eff_fmt keep their values.
- R5: With neither force nor automatic spare control sampled, all four tx_sp bits are 1.
- R6: With cfg_sp_force0 sampled as 1, tx_sp is 4'b0000, even if cfg_sp_auto is also 1.
- R7: With automatic spare control and no force, tx_sp[g] equals the sampled rx_hg_aligned[g] for each group g independently.
- R8: pay_mask bit 0 is the robbed-bit position. It is 0 when all of these hold: stomping is sampled on, the link is DS1 (cfg_e1=0), frame_pos mod 6 = 5 (frame_pos counts 0..23) and ts_pos < 24. In every other case pay_mask is 8'hFF.
- R9: With debounce on, an extracted code updates its channel only on the second consecutive matching detection. A differing code discards the pending candidate, so pattern A,B,B leaves the stored value unchanged.
- R10: With debounce off, an extracted code is stored on the next clock edge.
- R11: With the host selected as source (cfg_host_src=1), extracted codes are ignored and host writes are stored directly. Timeslot-16 stomping writes all ones to all 32 entries.
- R12: eff_fmt is 0 (two-state) when handling-group mode is sampled on, and equals the sampled cfg_sig_fmt otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mf_start | input | 1 | Multiframe boundary strobe; samples controls and status |
| cfg_e1 | input | 1 | Link is E1 (1) or DS1 (0) |
| cfg_auto_y | input | 1 | Automatic remote multiframe alarm |
| cfg_stomp | input | 1 | Robbed-bit stomping enable |
| cfg_debounce | input | 1 | Extracted signaling debounce enable |
| cfg_hg_en | input | 1 | Handling-group mode |
| cfg_sp_force0 | input | 1 | Force all spare bits to 0 |
| cfg_sp_auto | input | 1 | Spare bits follow group alignment |
| cfg_sig_fmt | input | 2 | Programmed signaling format |
| cfg_host_src | input | 1 | Host is the signaling source |
| host_y | input | 1 | Host-written alarm bit |
| rx_ts16_aligned | input | 1 | Receive TS16 multiframe aligned |
| rx_hg_aligned | input | 4 | Receive alignment per handling group |
| host_wr | input | 1 | Host code write strobe |
| host_ch | input | 5 | Host write channel |
| host_code | input | 4 | Host write code |
| ext_valid | input | 1 | Extracted code valid |
| ext_ch | input | 5 | Extracted code channel |
| ext_code | input | 4 | Extracted code |
| ts_pos | input | 5 | Current timeslot |
| frame_pos | input | 5 | Current frame in multiframe |
| rd_ch | input | 5 | Stored-code read channel |
| tx_y | output | 1 | Transmit remote multiframe alarm |
| tx_sp | output | 4 | Transmit spare bit per handling group |
| pay_mask | output | 8 | Payload bit mask for the current position |
| eff_fmt | output | 2 | Effective signaling format |
| rd_code | output | 4 | Stored code of channel rd_ch |

## Verification
The alarm logic is swept over all 16 combinations of link type, automatic mode, alignment and host value. This separates the automatic path from the host path. The spare bits are swept over all 64 combinations of force, automatic and group alignment. That exposes any mixing of groups or a wrong priority between force and automatic. The payload mask is swept over every frame and timeslot for each link type and stomp setting, which locates the robbed-bit frames and the voice-timeslot limit exactly. The code store is tried with single, doubled and interleaved codes, with debounce on and off and with host source selected. These patterns tell an immediate write from a debounced one and show whether a differing code clears the candidate.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    parameter int unsigned TSP_HG    = 4;
    parameter int unsigned TSP_FMT_W = 2;

    localparam logic [TSP_FMT_W-1:0] FMT_TWO_STATE = '0;

    typedef enum logic [1:0] {
        SP_DEFAULT = 2'd0,
        SP_FORCED  = 2'd1,
        SP_AUTO    = 2'd2
    } sp_state_t;

    typedef enum logic {
        DB_IDLE  = 1'b0,
        DB_ARMED = 1'b1
    } db_state_t;

    typedef struct packed {
        logic                 e1;
        logic                 auto_y;
        logic                 stomp;
        logic                 debounce;
        logic                 hg_en;
        logic                 sp_force0;
        logic                 sp_auto;
        logic [TSP_FMT_W-1:0] sig_fmt;
        logic                 host_src;
        logic                 host_y;
        logic                 ts16_al;
        logic [TSP_HG-1:0]    hg_al;
    } tsp_cfg_t;
endpackage

// File: rtl/tsp_cfg_sample.sv
module tsp_cfg_sample
    import tsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mf_start,
    input  tsp_cfg_t cfg_in,
    output tsp_cfg_t cfg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (mf_start) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/tsp_sp_fsm.sv
module tsp_sp_fsm
    import tsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mf_start,
    input  logic              force0,
    input  logic              auto_en,
    input  logic [TSP_HG-1:0] hg_al_q,
    output logic [TSP_HG-1:0] sp_out
);
    sp_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (mf_start) begin
            if (force0)       state_d = SP_FORCED;
            else if (auto_en) state_d = SP_AUTO;
            else              state_d = SP_DEFAULT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SP_DEFAULT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SP_DEFAULT: sp_out = '1;
            SP_FORCED:  sp_out = '0;
            SP_AUTO:    sp_out = hg_al_q;
            default:    sp_out = '1;
        endcase
    end
endmodule

// File: rtl/tsp_sig_store.sv
module tsp_sig_store
    import tsp_pkg::*;
#(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned CODE_W = 4,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              debounce,
    input  logic              host_src,
    input  logic              host_wr,
    input  logic [CH_W-1:0]   host_ch,
    input  logic [CODE_W-1:0] host_code,
    input  logic              ext_valid,
    input  logic [CH_W-1:0]   ext_ch,
    input  logic [CODE_W-1:0] ext_code,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CODE_W-1:0] rd_code
);
    logic [CODE_W-1:0] codes [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        db_state_t         st_q, st_d;
        logic [CODE_W-1:0] cand_q, cand_d;
        logic [CODE_W-1:0] code_q, code_d;
        logic              ext_hit, host_hit;

        assign ext_hit  = ext_valid && !host_src && (ext_ch == CH_W'(g));
        assign host_hit = host_wr && (host_ch == CH_W'(g));

        always_comb begin
            st_d   = st_q;
            cand_d = cand_q;
            code_d = code_q;
            if (host_hit) begin
                code_d = host_code;
                st_d   = DB_IDLE;
            end else if (ext_hit) begin
                if (!debounce) begin
                    code_d = ext_code;
                    st_d   = DB_IDLE;
                end else begin
                    unique case (st_q)
                        DB_IDLE: begin
                            cand_d = ext_code;
                            st_d   = DB_ARMED;
                        end
                        DB_ARMED: begin
                            if (ext_code == cand_q) code_d = ext_code;
                            st_d = DB_IDLE;
                        end
                        default: st_d = DB_IDLE;
                    endcase
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q   <= DB_IDLE;
                cand_q <= '0;
                code_q <= '0;
            end else begin
                st_q   <= st_d;
                cand_q <= cand_d;
                code_q <= code_d;
            end
        end

        assign codes[g] = code_q;
    end

    assign rd_code = codes[rd_ch];
endmodule

// File: rtl/tx_sig_proc.sv
module tx_sig_proc
    import tsp_pkg::*;
#(
    parameter int unsigned NUM_CH     = 32,
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned VOICE_TS   = 24,
    parameter int unsigned ROB_PERIOD = 6,
    parameter int unsigned POS_W      = 5,
    localparam int unsigned CH_W      = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mf_start,
    input  logic                 cfg_e1,
    input  logic                 cfg_auto_y,
    input  logic                 cfg_stomp,
    input  logic                 cfg_debounce,
    input  logic                 cfg_hg_en,
    input  logic                 cfg_sp_force0,
    input  logic                 cfg_sp_auto,
    input  logic [TSP_FMT_W-1:0] cfg_sig_fmt,
    input  logic                 cfg_host_src,
    input  logic                 host_y,
    input  logic                 rx_ts16_aligned,
    input  logic [TSP_HG-1:0]    rx_hg_aligned,
    input  logic                 host_wr,
    input  logic [CH_W-1:0]      host_ch,
    input  logic [CODE_W-1:0]    host_code,
    input  logic                 ext_valid,
    input  logic [CH_W-1:0]      ext_ch,
    input  logic [CODE_W-1:0]    ext_code,
    input  logic [POS_W-1:0]     ts_pos,
    input  logic [POS_W-1:0]     frame_pos,
    input  logic [CH_W-1:0]      rd_ch,
    output logic                 tx_y,
    output logic [TSP_HG-1:0]    tx_sp,
    output logic [7:0]           pay_mask,
    output logic [TSP_FMT_W-1:0] eff_fmt,
    output logic [CODE_W-1:0]    rd_code
);
    localparam logic [POS_W-1:0] ROB_LAST = POS_W'(ROB_PERIOD - 1);

    tsp_cfg_t cfg_in, cfg_q;
    logic     robbed_slot;

    always_comb begin
        cfg_in.e1        = cfg_e1;
        cfg_in.auto_y    = cfg_auto_y;
        cfg_in.stomp     = cfg_stomp;
        cfg_in.debounce  = cfg_debounce;
        cfg_in.hg_en     = cfg_hg_en;
        cfg_in.sp_force0 = cfg_sp_force0;
        cfg_in.sp_auto   = cfg_sp_auto;
        cfg_in.sig_fmt   = cfg_sig_fmt;
        cfg_in.host_src  = cfg_host_src;
        cfg_in.host_y    = host_y;
        cfg_in.ts16_al   = rx_ts16_aligned;
        cfg_in.hg_al     = rx_hg_aligned;
    end

    tsp_cfg_sample u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mf_start (mf_start),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q)
    );

    tsp_sp_fsm u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .mf_start (mf_start),
        .force0   (cfg_sp_force0),
        .auto_en  (cfg_sp_auto),
        .hg_al_q  (cfg_q.hg_al),
        .sp_out   (tx_sp)
    );

    tsp_sig_store #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .debounce  (cfg_q.debounce),
        .host_src  (cfg_q.host_src),
        .host_wr   (host_wr),
        .host_ch   (host_ch),
        .host_code (host_code),
        .ext_valid (ext_valid),
        .ext_ch    (ext_ch),
        .ext_code  (ext_code),
        .rd_ch     (rd_ch),
        .rd_code   (rd_code)
    );

    // Alarm bit: automatic path only on E1 links
    assign tx_y = (cfg_q.e1 && cfg_q.auto_y) ? !cfg_q.ts16_al : cfg_q.host_y;

    // Handling-group mode forces two-state signaling
    assign eff_fmt = cfg_q.hg_en ? FMT_TWO_STATE : cfg_q.sig_fmt;

    // Robbed-bit frames and voice timeslots of a DS1 link
    assign robbed_slot = ((frame_pos % POS_W'(ROB_PERIOD)) == ROB_LAST)
                      && (ts_pos < POS_W'(VOICE_TS));

    always_comb begin
        pay_mask = 8'hFF;
        if (cfg_q.stomp && !cfg_q.e1 && robbed_slot) pay_mask[0] = 1'b0;
    end
endmodule

// File: rtl/tx_sig_proc_chk.sv
module tx_sig_proc_chk
    import tsp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mf_start,
    input logic              cfg_e1,
    input logic              cfg_auto_y,
    input logic              cfg_hg_en,
    input logic              cfg_sp_force0,
    input logic              cfg_sp_auto,
    input logic              rx_ts16_aligned,
    input logic [TSP_HG-1:0] rx_hg_aligned,
    input logic              tx_y,
    input logic [TSP_HG-1:0] tx_sp,
    input logic [TSP_FMT_W-1:0] eff_fmt
);
    assert_hold_between_mf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_start |=> ($stable(tx_y) && $stable(tx_sp) && $stable(eff_fmt)));

    assert_y_auto_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_start && cfg_e1 && cfg_auto_y) |=> (tx_y == !$past(rx_ts16_aligned)));

    assert_sp_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_start && cfg_sp_force0) |=> (tx_sp == '0));

    assert_sp_auto_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_start && !cfg_sp_force0 && cfg_sp_auto) |=> (tx_sp == $past(rx_hg_aligned)));

    assert_sp_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_start && !cfg_sp_force0 && !cfg_sp_auto) |=> (tx_sp == '1));

    assert_two_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_start && cfg_hg_en) |=> (eff_fmt == FMT_TWO_STATE));
endmodule

bind tx_sig_proc tx_sig_proc_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mf_start        (mf_start),
    .cfg_e1          (cfg_e1),
    .cfg_auto_y      (cfg_auto_y),
    .cfg_hg_en       (cfg_hg_en),
    .cfg_sp_force0   (cfg_sp_force0),
    .cfg_sp_auto     (cfg_sp_auto),
    .rx_ts16_aligned (rx_ts16_aligned),
    .rx_hg_aligned   (rx_hg_aligned),
    .tx_y            (tx_y),
    .tx_sp           (tx_sp),
    .eff_fmt         (eff_fmt)
);

// File: tb/tx_sig_proc_bench.sv
module tx_sig_proc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mf_start = 1'b0;
    logic       cfg_e1 = 1'b0, cfg_auto_y = 1'b0, cfg_stomp = 1'b0, cfg_debounce = 1'b0;
    logic       cfg_hg_en = 1'b0, cfg_sp_force0 = 1'b0, cfg_sp_auto = 1'b0, cfg_host_src = 1'b0;
    logic [1:0] cfg_sig_fmt = 2'd0;
    logic       host_y = 1'b0, rx_ts16_aligned = 1'b0;
    logic [3:0] rx_hg_aligned = 4'd0;
    logic       host_wr = 1'b0, ext_valid = 1'b0;
    logic [4:0] host_ch = 5'd0, ext_ch = 5'd0, ts_pos = 5'd0, frame_pos = 5'd0, rd_ch = 5'd0;
    logic [3:0] host_code = 4'd0, ext_code = 4'd0;
    logic       tx_y;
    logic [3:0] tx_sp;
    logic [7:0] pay_mask;
    logic [1:0] eff_fmt;
    logic [3:0] rd_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tx_sig_proc u_tx_sig_proc (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_mf();
        mf_start = 1'b1;
        @(negedge clk);
        mf_start = 1'b0;
    endtask

    task automatic ext_put(input int ch, input int code);
        ext_ch = 5'(ch); ext_code = 4'(code); ext_valid = 1'b1;
        @(negedge clk);
        ext_valid = 1'b0;
    endtask

    task automatic read_code(input int ch, input string req, input int exp);
        rd_ch = 5'(ch);
        #1;
        chk(req, int'(rd_code), exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_y", int'(tx_y), 0);
        chk("R1 tx_sp", int'(tx_sp), 15);
        chk("R1 eff_fmt", int'(eff_fmt), 0);
        chk("R1 pay_mask", int'(pay_mask), 255);
        read_code(7, "R1 code", 0);

        // R2 / R3 alarm sweep
        for (int v = 0; v < 16; v++) begin
            cfg_e1 = v[0]; cfg_auto_y = v[1]; rx_ts16_aligned = v[2]; host_y = v[3];
            pulse_mf();
            if (v[0] && v[1]) chk("R2 tx_y", int'(tx_y), int'(!v[2]));
            else              chk("R3 tx_y", int'(tx_y), int'(v[3]));
        end

        // R4 no update without boundary
        cfg_e1 = 1'b1; cfg_auto_y = 1'b1; rx_ts16_aligned = 1'b1;
        pulse_mf();
        rx_ts16_aligned = 1'b0; cfg_sp_force0 = 1'b1; cfg_hg_en = 1'b1; cfg_sig_fmt = 2'd3;
        repeat (3) @(negedge clk);
        chk("R4 tx_y held", int'(tx_y), 0);
        chk("R4 tx_sp held", int'(tx_sp), 15);
        pulse_mf();
        chk("R4 tx_y after boundary", int'(tx_y), 1);

        // R5 / R6 / R7 spare sweep
        for (int v = 0; v < 64; v++) begin
            cfg_sp_force0 = v[0]; cfg_sp_auto = v[1]; rx_hg_aligned = 4'(v >> 2);
            pulse_mf();
            if (v[0])      chk("R6 tx_sp", int'(tx_sp), 0);
            else if (v[1]) chk("R7 tx_sp", int'(tx_sp), v >> 2);
            else           chk("R5 tx_sp", int'(tx_sp), 15);
        end
        cfg_sp_force0 = 1'b0; cfg_sp_auto = 1'b0;

        // R12 format sweep
        for (int v = 0; v < 8; v++) begin
            cfg_hg_en = v[2]; cfg_sig_fmt = 2'(v);
            pulse_mf();
            chk("R12 eff_fmt", int'(eff_fmt), v[2] ? 0 : (v & 3));
        end

        // R8 mask sweep
        for (int m = 0; m < 4; m++) begin
            cfg_e1 = m[0]; cfg_stomp = m[1];
            pulse_mf();
            for (int f = 0; f < 24; f++) begin
                for (int t = 0; t < 32; t++) begin
                    frame_pos = 5'(f); ts_pos = 5'(t);
                    #1;
                    chk("R8 pay_mask", int'(pay_mask),
                        (m[1] && !m[0] && (f % 6 == 5) && t < 24) ? 254 : 255);
                end
            end
        end

        // R10 immediate store
        cfg_debounce = 1'b0; cfg_host_src = 1'b0;
        pulse_mf();
        ext_put(3, 9);
        read_code(3, "R10 immediate", 9);
        ext_put(3, 5);
        read_code(3, "R10 overwrite", 5);

        // R9 debounce
        cfg_debounce = 1'b1;
        pulse_mf();
        ext_put(10, 6);
        read_code(10, "R9 single detect", 0);
        ext_put(10, 6);
        read_code(10, "R9 double detect", 6);
        ext_put(10, 2);
        ext_put(10, 12);
        ext_put(10, 12);
        read_code(10, "R9 A,B,B cleared", 6);
        ext_put(10, 12);
        read_code(10, "R9 commit after clear", 12);
        ext_put(11, 4);
        ext_put(12, 4);
        read_code(11, "R9 channel isolation", 0);
        read_code(12, "R9 channel isolation", 0);

        // R11 host source and TS16 stomp
        cfg_host_src = 1'b1; cfg_debounce = 1'b0;
        pulse_mf();
        ext_put(3, 1);
        read_code(3, "R11 extracted ignored", 5);
        for (int c = 0; c < 32; c++) begin
            host_ch = 5'(c); host_code = 4'hF; host_wr = 1'b1;
            @(negedge clk);
        end
        host_wr = 1'b0;
        for (int c = 0; c < 32; c++) read_code(c, "R11 all ones", 15);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule